// File: doc/BRIEF.md
# Infrared Port Mode Configuration Gate

This block holds the programmable settings of an infrared transceiver port: a configuration word with the transmit, receive, loopback, polarity, filter and line-coding selections, and a staged physical-layer timing word that packs a baud divisor, a pulse width and a preamble length. The line-coding selections, the short-CRC selection and the staged timing word do not reach the running datapath when they are written. They are copied into the applied state only when the enable bit of the enable/status register goes from 0 to 1. Software programs the next mode while the port runs or is stopped, then toggles the enable bit to switch over cleanly.

At the enable edge the block checks that at most one of the three line-coding selections is set. If more than one is set, it raises a configuration error flag, turns on no line coding and keeps the timing word that was applied before. The enable/status register also reports live transmit-enable and receive-enable status. Receive is reported as enabled only when it is selected and transmit is either off or loopback is on. Access is through a simple register bus with write and read strobes, a two-bit word address and an access-size flag. Read data appears one cycle after the read strobe.

Top module: `ircfg_gate`

## Requirements
- R1: After reset, every register reads 0, all applied line-coding and short-CRC outputs are 0, the configuration error is 0 and the applied timing fields are 0.
- R2: Address 0 is the configuration word. A 16-bit write (bus_word=1) stores bits 14 (loopback), 12 (transmit enable), 11 (receive enable), 10 (master), 7 (short CRC), 6 (FIR), 5 (MIR), 4 (SIR), 3 (SIR filter), 2 (filter test), 1 (tx invert) and 0 (rx invert). Bits 15, 13, 9 and 8 read as 0. Read data is valid in the cycle after the read strobe.
- R3: A write to the configuration word with bus_word=0 (byte size) leaves it unchanged.
- R4: Address 1 is the staged timing word. A 16-bit write stores all 16 bits. A byte write updates only bits [7:0]. Neither changes the applied timing outputs.
- R5: A 0-to-1 change of enable bit 15 (a 16-bit write to address 3) with at most one of bits 6..4 set copies bits 6, 5 and 4 into the FIR-on (13), MIR-on (12) and SIR-on (11) status bits. It copies bit 7 into short-CRC-on (8) and the staged word into the applied word at address 2. The applied word is baud [15:10], pulse width [9:5] and preamble [4:0].
- R6: While bit 15 stays 1, writes to the configuration word, to the staged word, or further writes with bit 15 = 1 do not change the applied mode bits or the applied word.
- R7: If more than one of bits 6..4 is set at the enable edge, error bit 14 is set, no mode-on bit and no short-CRC-on bit is set, and the previously applied word is kept.
- R8: A 16-bit write to address 3 with bit 15 = 0 clears the enable, the mode-on bits, short-CRC-on and the error bit. The applied word stays readable.
- R9: Status bit 10 equals configuration bit 12 at all times. Status bit 9 equals bit 11 AND (NOT bit 12 OR bit 14).
- R10: Address 3 reads only bits [15:8], with [7:0] as 0. Writes to address 2 are ignored. A byte write to address 3 does not change bit 15.
- R11: The applied timing fields, mode-on, error and enable status ports carry the same values as the corresponding register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| phy_baud | output | 6 | Applied baud divisor |
| phy_width | output | 5 | Applied pulse width |
| phy_preamble | output | 5 | Applied preamble length |
| sir_on | output | 1 | SIR coding applied |
| mir_on | output | 1 | MIR coding applied |
| fir_on | output | 1 | FIR coding applied |
| crc16_on | output | 1 | Short CRC applied |
| cfg_error | output | 1 | Illegal mode seen at last enable edge |
| tx_on | output | 1 | Transmit enable status |
| rx_on | output | 1 | Receive enable status |
| loop_on | output | 1 | Loopback selection |
| tx_invert | output | 1 | Transmit polarity inversion |
| rx_invert | output | 1 | Receive polarity inversion |
| master_on | output | 1 | Master enable selection |
| sir_filter | output | 1 | SIR receive filter selection |
| filter_test | output | 1 | Filter test selection |

## Verification
The hardest situation to reach is an illegal mode at the enable edge that must leave an older applied timing word in place. Reaching it needs a legal apply, then a new staged word, then a bad mode, all in that order. The bench sweeps all 64 combinations of the three coding bits with transmit, receive and loopback. For each one it stages a fresh timing word and pulses the enable. Its own model of the last legally applied word predicts what address 2 and the timing ports must show after each edge. This exercises both the legal and the illegal apply paths, and the live receive-status formula.

// File: rtl/ircfg_pkg.sv
// Package: shared register addresses, bit positions and helper functions
// for the infrared mode configuration gate.
package ircfg_pkg;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_NPHY = 2'd1,
        A_CPHY = 2'd2,
        A_ENA  = 2'd3
    } reg_addr_e;

    // configuration word bit positions
    localparam int B_LOOP  = 14;
    localparam int B_TXEN  = 12;
    localparam int B_RXEN  = 11;
    localparam int B_MSTR  = 10;
    localparam int B_CRC   = 7;
    localparam int B_FIR   = 6;
    localparam int B_MIR   = 5;
    localparam int B_SIR   = 4;
    localparam int B_FILT  = 3;
    localparam int B_FTEST = 2;
    localparam int B_TXPOL = 1;
    localparam int B_RXPOL = 0;

    // writable bits of the configuration word
    localparam logic [REG_W-1:0] CFG_WMASK = 16'h5CFF;

    // enable register bit positions
    localparam int E_EN   = 15;
    localparam int E_ERR  = 14;

    // more than one of three mode selections set
    function automatic logic mode_clash(input logic [2:0] m);
        return (m[0] & m[1]) | (m[0] & m[2]) | (m[1] & m[2]);
    endfunction

    // receive status: selected and (no transmit or loopback)
    function automatic logic rx_status(input logic rx, input logic tx, input logic loop);
        return rx & (~tx | loop);
    endfunction
endpackage

// File: rtl/ircfg_regs.sv
// Module: register-bus write decode and storage of the configuration and
// staged timing words. Assumes one access per strobe; byte accesses carry
// their data in bus_wdata[7:0]. Produces enable set/clear pulses for the
// apply stage; the enable bit itself lives there.
module ircfg_regs
    import ircfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_word,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] cfg_q,
    output logic [REG_W-1:0] nphy_q,
    output logic             ena_set,
    output logic             ena_clr
);
    logic wr_cfg, wr_nphy, wr_ena;

    // address decode of the write strobe
    always_comb begin
        wr_cfg  = bus_wr && (bus_addr == A_CFG);
        wr_nphy = bus_wr && (bus_addr == A_NPHY);
        wr_ena  = bus_wr && (bus_addr == A_ENA) && bus_word;
        ena_set = wr_ena &&  bus_wdata[E_EN];
        ena_clr = wr_ena && !bus_wdata[E_EN];
    end

    // configuration word: 16-bit writes only, reserved bits forced to 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_cfg && bus_word)
            cfg_q <= bus_wdata & CFG_WMASK;
    end

    // staged timing word: full write or low-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)
            nphy_q <= '0;
        else if (wr_nphy) begin
            if (bus_word)
                nphy_q <= bus_wdata;
            else
                nphy_q[7:0] <= bus_wdata[7:0];
        end
    end

    assert_cfg_byte_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CFG && !bus_word) |=> $stable(cfg_q));

    assert_nphy_byte_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_NPHY && !bus_word) |=> $stable(nphy_q[15:8]));
endmodule

// File: rtl/ircfg_apply.sv
// Module: enable-edge gate. On a 0->1 change of the enable bit it checks the
// line-coding selection and either applies mode, short-CRC and the staged
// timing word, or flags an error and keeps the old timing word. Clearing
// the enable drops the mode, CRC and error state.
module ircfg_apply
    import ircfg_pkg::*;
#(
    parameter int PHY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena_set,
    input  logic             ena_clr,
    input  logic [3:0]       sel_crc_mode,  // {crc, fir, mir, sir}
    input  logic [PHY_W-1:0] nphy_q,
    output logic             en_q,
    output logic             err_q,
    output logic [2:0]       mode_on,       // {fir, mir, sir}
    output logic             crc_on,
    output logic [PHY_W-1:0] cphy_q
);
    logic rise, clash;

    // detect the rising edge and check the mode selection
    always_comb begin
        rise  = ena_set && !en_q;
        clash = mode_clash(sel_crc_mode[2:0]);
    end

    // enable, error and applied mode state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            err_q   <= 1'b0;
            mode_on <= '0;
            crc_on  <= 1'b0;
        end else if (ena_clr) begin
            en_q    <= 1'b0;
            err_q   <= 1'b0;
            mode_on <= '0;
            crc_on  <= 1'b0;
        end else if (rise) begin
            en_q    <= 1'b1;
            err_q   <= clash;
            mode_on <= clash ? 3'b000 : sel_crc_mode[2:0];
            crc_on  <= clash ? 1'b0   : sel_crc_mode[3];
        end
    end

    // applied timing word: taken only at a legal edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            cphy_q <= '0;
        else if (rise && !clash)
            cphy_q <= nphy_q;
    end

    assert_mode_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_on));

    assert_stable_while_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> ($stable(cphy_q) && $stable(mode_on) && $stable(crc_on)));

    assert_error_blocks_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (mode_on == 3'b000 && !crc_on));

    assert_disabled_no_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (mode_on == 3'b000 && !crc_on && !err_q));
endmodule

// File: rtl/ircfg_readmux.sv
// Module: registered read-data selection. Assumes the enable-status byte is
// assembled by the caller; the low byte of the enable register reads 0.
module ircfg_readmux
    import ircfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] cfg_q,
    input  logic [REG_W-1:0] nphy_q,
    input  logic [REG_W-1:0] cphy_q,
    input  logic [7:0]       ena_hi,
    output logic [REG_W-1:0] bus_rdata
);
    logic [REG_W-1:0] sel;

    // pick the addressed register
    always_comb begin
        unique case (bus_addr)
            A_CFG:   sel = cfg_q;
            A_NPHY:  sel = nphy_q;
            A_CPHY:  sel = cphy_q;
            default: sel = {ena_hi, 8'h00};
        endcase
    end

    // capture read data on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= sel;
    end

    assert_ena_low_byte_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ENA) |=> (bus_rdata[7:0] == 8'h00));
endmodule

// File: rtl/ircfg_gate.sv
// Module: top of the infrared mode configuration gate. Wires the register
// storage, the enable-edge apply stage and the read mux, and forms the live
// transmit/receive status. Assumes BAUD_W+WID_W+PRE_W equals the 16-bit
// register width.
module ircfg_gate
    import ircfg_pkg::*;
#(
    parameter int BAUD_W = 6,
    parameter int WID_W  = 5,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_word,
    input  logic [1:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [BAUD_W-1:0] phy_baud,
    output logic [WID_W-1:0]  phy_width,
    output logic [PRE_W-1:0]  phy_preamble,
    output logic              sir_on,
    output logic              mir_on,
    output logic              fir_on,
    output logic              crc16_on,
    output logic              cfg_error,
    output logic              tx_on,
    output logic              rx_on,
    output logic              loop_on,
    output logic              tx_invert,
    output logic              rx_invert,
    output logic              master_on,
    output logic              sir_filter,
    output logic              filter_test
);
    localparam int PHY_W = BAUD_W + WID_W + PRE_W;

    logic [REG_W-1:0] cfg_q, nphy_q;
    logic [PHY_W-1:0] cphy_q;
    logic             ena_set, ena_clr, en_q, err_q, crc_on;
    logic [2:0]       mode_on;
    logic [7:0]       ena_hi;

    ircfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg_q     (cfg_q),
        .nphy_q    (nphy_q),
        .ena_set   (ena_set),
        .ena_clr   (ena_clr)
    );

    ircfg_apply #(.PHY_W(PHY_W)) u_apply (
        .clk          (clk),
        .rst_n        (rst_n),
        .ena_set      (ena_set),
        .ena_clr      (ena_clr),
        .sel_crc_mode (cfg_q[B_CRC:B_SIR]),
        .nphy_q       (nphy_q),
        .en_q         (en_q),
        .err_q        (err_q),
        .mode_on      (mode_on),
        .crc_on       (crc_on),
        .cphy_q       (cphy_q)
    );

    // live status and decoded selections
    always_comb begin
        tx_on       = cfg_q[B_TXEN];
        rx_on       = rx_status(cfg_q[B_RXEN], cfg_q[B_TXEN], cfg_q[B_LOOP]);
        loop_on     = cfg_q[B_LOOP];
        master_on   = cfg_q[B_MSTR];
        sir_filter  = cfg_q[B_FILT];
        filter_test = cfg_q[B_FTEST];
        tx_invert   = cfg_q[B_TXPOL];
        rx_invert   = cfg_q[B_RXPOL];
        fir_on      = mode_on[2];
        mir_on      = mode_on[1];
        sir_on      = mode_on[0];
        crc16_on    = crc_on;
        cfg_error   = err_q;
        phy_baud    = cphy_q[PHY_W-1 -: BAUD_W];
        phy_width   = cphy_q[PRE_W +: WID_W];
        phy_preamble = cphy_q[PRE_W-1:0];
        ena_hi      = {en_q, err_q, mode_on, tx_on, rx_on, crc_on};
    end

    ircfg_readmux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .cfg_q     (cfg_q),
        .nphy_q    (nphy_q),
        .cphy_q    (cphy_q),
        .ena_hi    (ena_hi),
        .bus_rdata (bus_rdata)
    );

    assert_rx_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_on && !loop_on) |-> !tx_on);
endmodule

// File: tb/tb_ircfg_gate.sv
module tb_ircfg_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [5:0]  phy_baud;
    logic [4:0]  phy_width, phy_preamble;
    logic sir_on, mir_on, fir_on, crc16_on, cfg_error, tx_on, rx_on;
    logic loop_on, tx_invert, rx_invert, master_on, sir_filter, filter_test;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model of applied state
    logic        m_en, m_err, m_crc;
    logic [2:0]  m_mode;
    logic [15:0] m_cphy, m_cfg, m_nphy;

    ircfg_gate dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic word);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_word = word;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] exp_ena();
        logic rxs;
        rxs = m_cfg[11] & (~m_cfg[12] | m_cfg[14]);
        return {m_en, m_err, m_mode, m_cfg[12], rxs, m_crc, 8'h00};
    endfunction

    task automatic model_enable();
        if (!m_en) begin
            m_en = 1'b1;
            if ($countones(m_cfg[6:4]) > 1) begin
                m_err = 1'b1; m_mode = 3'b000; m_crc = 1'b0;
            end else begin
                m_err = 1'b0; m_mode = m_cfg[6:4]; m_crc = m_cfg[7]; m_cphy = m_nphy;
            end
        end
    endtask

    task automatic model_disable();
        m_en = 1'b0; m_err = 1'b0; m_mode = 3'b000; m_crc = 1'b0;
    endtask

    task automatic check_ports(input string tag);
        check({tag, " phy fields R11"}, {phy_baud, phy_width, phy_preamble}, m_cphy);
        check({tag, " mode ports R11"}, {13'h0, fir_on, mir_on, sir_on}, {13'h0, m_mode});
        check({tag, " crc/err ports R11"}, {14'h0, crc16_on, cfg_error}, {14'h0, m_crc, m_err});
    endtask

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        m_en = 0; m_err = 0; m_crc = 0; m_mode = 0; m_cphy = 0; m_cfg = 0; m_nphy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("reset cfg R1", d, 16'h0);
        rd(2'd1, d); check("reset nphy R1", d, 16'h0);
        rd(2'd2, d); check("reset cphy R1", d, 16'h0);
        rd(2'd3, d); check("reset ena R1", d, 16'h0);
        check_ports("reset R1");

        // R2 reserved bits masked
        wr(2'd0, 16'hFFFF, 1'b1); m_cfg = 16'h5CFF;
        rd(2'd0, d); check("cfg mask R2", d, 16'h5CFF);
        // R3 byte write ignored
        wr(2'd0, 16'h0000, 1'b0);
        rd(2'd0, d); check("cfg byte ignored R3", d, 16'h5CFF);
        check("tx_on port R9", {15'h0, tx_on}, 16'h1);
        check("rx_on with loop R9", {15'h0, rx_on}, 16'h1);
        wr(2'd0, 16'h0000, 1'b1); m_cfg = 0;

        // R4 staged word full and byte writes
        wr(2'd1, 16'hBEEF, 1'b1);
        wr(2'd1, 16'h1234, 1'b0); m_nphy = 16'hBE34;
        rd(2'd1, d); check("nphy byte low only R4", d, 16'hBE34);
        rd(2'd2, d); check("nphy not applied R4", d, 16'h0000);
        check_ports("staged R4");

        // R10 write to applied word ignored, byte write to enable ignored
        wr(2'd2, 16'hFFFF, 1'b1);
        rd(2'd2, d); check("cphy read-only R10", d, 16'h0000);
        wr(2'd3, 16'hFFFF, 1'b0);
        rd(2'd3, d); check("ena byte write R10", d, exp_ena());

        // R5..R9 sweep of coding bits, tx, rx, loop
        for (int i = 0; i < 64; i++) begin
            logic [15:0] c;
            c = 16'h0;
            c[6:4] = i[2:0]; c[12] = i[3]; c[11] = i[4]; c[14] = i[5];
            c[7] = i[0] ^ i[5]; c[10] = 1'b1; c[3:0] = i[3:0];
            wr(2'd0, c, 1'b1); m_cfg = c;
            m_nphy = 16'(i * 16'h0413) ^ 16'hA5C3;
            wr(2'd1, m_nphy, 1'b1);
            rd(2'd3, d); check("live status R9", d, exp_ena());
            wr(2'd3, 16'h8000, 1'b1); model_enable();
            rd(2'd3, d); check("enable edge R5 R7", d, exp_ena());
            rd(2'd2, d); check("applied word R5 R7", d, m_cphy);
            check_ports("sweep");
            // R6 changes while enabled have no effect
            wr(2'd0, c ^ 16'h00F0, 1'b1); m_cfg = c ^ 16'h00F0;
            wr(2'd1, ~m_nphy, 1'b1); m_nphy = ~m_nphy;
            wr(2'd3, 16'h8000, 1'b1); model_enable();
            rd(2'd3, d); check("no reapply R6", d, exp_ena());
            rd(2'd2, d); check("word held R6", d, m_cphy);
            // R8 clear
            wr(2'd3, 16'h0000, 1'b1); model_disable();
            rd(2'd3, d); check("disable clears R8", d, exp_ena());
            rd(2'd2, d); check("word kept R8", d, m_cphy);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule